// File: doc/BRIEF.md
# SPI Serial EEPROM Command and Status Controller

This block is the serial slave side of a small byte-addressed nonvolatile store of 512 bytes. Here the store is modelled as a register array. A host drives the chip select, serial clock and data-in lines in SPI mode 0. The block collects an 8-bit instruction, an optional address byte and any number of data bytes. It answers reads by shifting array bytes or the status byte out on the data-out line. A write-enable latch, two block-protect bits and two watchdog-select bits gate which writes are allowed and are kept in a status byte. The internal programming time is modelled by a busy interval that lasts a fixed number of system clocks.

The serial lines are sampled with the system clock, and each SCK edge is found by comparing the line with its value in the previous clock. The data-out line comes with a drive-enable output for the pad. The clock may stop for any length of time between edges. A write is collected into a page buffer and committed to the array in one step when chip select rises, then the busy interval starts. Instructions arriving during the busy interval are discarded, except a status read.

Top module: `spi_ee_ctrl`

## Requirements
- R1: SI is sampled on each rising SCK while chip select is low, starting with the first rise after chip select falls. All bytes move most significant bit first. SO changes after falling SCK, so the first bit of each output byte is valid before the rising edge that starts that byte.
- R2: READ is 0x03, or 0x0B when address bit 8 is 1. Bit 3 of the opcode is address bit 8 and the next byte is address bits 7..0. After that, array bytes stream out from that address, and the address increments by one per byte and wraps from 0x1FF to 0x000.
- R3: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. Neither takes address or data. The latch reads in status bit 1.
- R4: Opcode 0x05 streams the status byte, repeated for as long as chip select stays low. The byte is bits 7:6 = 0, bits 5:4 = watchdog select, bits 3:2 = block protect, bit 1 = latch, bit 0 = busy. Opcode 0x01 followed by a whole data byte loads bits 5:2 from that byte on chip-select rise, if the latch is set, and the other bits of that byte are ignored.
- R5: WRITE is 0x02, or 0x0A when address bit 8 is 1, followed by the address byte and data. It takes effect only on chip-select rise, only if at least one data byte and no partial byte was received, and only if the latch was set. A refused write leaves the array, the busy bit and the latch unchanged. After a status or array write, the latch stays set through the busy interval and clears when the interval ends.
- R6: Data bytes of one WRITE go to consecutive locations inside the 4-byte aligned page of the start address, and wrap to the page start. A later byte overwrites an earlier byte at the same location.
- R7: Block protect 00 protects nothing, 01 protects 0x180-0x1FF, 10 protects 0x100-0x1FF and 11 protects the whole array. A WRITE whose start address is protected is refused. Protected locations still read normally.
- R8: A committed write sets the busy bit for WRITE_CYCLES clocks. While busy, the status byte reads 0xFF, and every instruction other than 0x05 is discarded.
- R9: While the write-protect input is low, the latch is held clear and 0x06 cannot set it. Reads still work.
- R10: After reset the latch, the busy bit, block protect and watchdog select are all 0. The SO drive enable is 0 whenever chip select is high, and is 1 while read or status data is being shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial lines |
| rst_n | input | 1 | Active-low power-on reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_si | input | 1 | Serial data from the host |
| spi_wp_n | input | 1 | Active-low write protect |
| spi_so | output | 1 | Serial data to the host |
| spi_so_oe | output | 1 | Drive enable for the SO pad |

## Verification
Two events can land in the same cycle: the end of the busy interval, which clears both the busy bit and the latch, and a new instruction or status byte that reads those bits. The bench issues a status read and a discarded WREN right after each commit, while the interval is still running. It then expects 0xFF during the interval and a clear latch afterwards. The bench also lets a write-protect pulse clear the latch while a write is being collected, and judges the result by the later status byte and by reading the array back.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

    localparam int ADDR_LO_W = 8;
    localparam int ADDR_W    = ADDR_LO_W + 1;
    localparam int DEPTH     = 1 << ADDR_W;
    localparam int A8_BIT    = 3;

    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_WRSR  = 8'h01;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRITE = 8'h02;
    localparam logic [7:0] OP_A8_MASK = 8'(1 << A8_BIT);

    typedef enum logic [2:0] {
        PH_CMD,
        PH_ADDR,
        PH_WDATA,
        PH_RDATA,
        PH_SRD,
        PH_SRW,
        PH_IGN
    } phase_e;

endpackage

// File: rtl/spi_ee_sample.sv
module spi_ee_sample (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_rise
);
    typedef struct packed {
        logic sck;
        logic cs_n;
    } smp_t;

    smp_t q, d;

    always_comb begin
        d.sck  = sck;
        d.cs_n = cs_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sck  <= 1'b0;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sck_rise = sck & ~q.sck;
    assign sck_fall = ~sck & q.sck;
    assign cs_rise  = cs_n & ~q.cs_n;

endmodule

// File: rtl/spi_ee_protect.sv
module spi_ee_protect #(
    parameter int ADDR_W = 9
) (
    input  logic [1:0]        bl,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    always_comb begin
        unique case (bl)
            2'b00:   hit = 1'b0;
            2'b01:   hit = (addr[ADDR_W-1 -: 2] == 2'b11);
            2'b10:   hit = addr[ADDR_W-1];
            default: hit = 1'b1;
        endcase
    end
endmodule

// File: rtl/spi_ee_busy.sv
module spi_ee_busy #(
    parameter int CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic wip,
    output logic done
);
    localparam int W = $clog2(CYCLES + 1);

    logic [W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        done  = 1'b0;
        if (start) begin
            cnt_d = W'(CYCLES);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
            done  = (cnt_q == W'(1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign wip = (cnt_q != '0);

    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !wip); // R8
    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> wip); // R8
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !wip); // R8

endmodule

// File: rtl/spi_ee_array.sv
module spi_ee_array #(
    parameter int ADDR_W     = 9,
    parameter int PAGE_BYTES = 4
) (
    input  logic                            clk,
    input  logic                            we,
    input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] wr_page,
    input  logic [PAGE_BYTES-1:0]           wr_mask,
    input  logic [PAGE_BYTES-1:0][7:0]      wr_data,
    input  logic [ADDR_W-1:0]               rd_addr,
    output logic [7:0]                      rd_data
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int COL_W = $clog2(PAGE_BYTES);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (wr_mask[i]) mem[{wr_page, COL_W'(i)}] <= wr_data[i];
            end
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/spi_ee_ctrl.sv
module spi_ee_ctrl
    import spi_ee_pkg::*;
#(
    parameter int PAGE_BYTES   = 4,
    parameter int WRITE_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sck,
    input  logic spi_cs_n,
    input  logic spi_si,
    input  logic spi_wp_n,
    output logic spi_so,
    output logic spi_so_oe
);
    localparam int COL_W  = $clog2(PAGE_BYTES);
    localparam int PAGE_W = ADDR_W - COL_W;

    typedef struct packed {
        phase_e                        ph;
        logic [2:0]                    bit_cnt;
        logic [7:0]                    sh;
        logic [ADDR_W-1:0]             addr;
        logic                          rd_op;
        logic [COL_W-1:0]              col;
        logic [PAGE_BYTES-1:0][7:0]    pbuf;
        logic [PAGE_BYTES-1:0]         pmask;
        logic                          got_byte;
        logic [3:0]                    sr_data;
        logic                          sr_got;
        logic [7:0]                    tx;
        logic                          so;
        logic                          wel;
        logic [1:0]                    bl;
        logic [1:0]                    wd;
    } st_t;

    st_t q, d;

    logic       sck_rise, sck_fall, cs_rise;
    logic       prot_hit;
    logic       wip, busy_done, busy_start;
    logic       mem_we;
    logic [7:0] rd_data;
    logic [7:0] status_byte;
    logic [7:0] sh_n;
    logic [7:0] src;

    spi_ee_sample u_sample (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (spi_sck),
        .cs_n     (spi_cs_n),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .cs_rise  (cs_rise)
    );

    spi_ee_protect #(.ADDR_W(ADDR_W)) u_protect (
        .bl   (q.bl),
        .addr (q.addr),
        .hit  (prot_hit)
    );

    spi_ee_busy #(.CYCLES(WRITE_CYCLES)) u_busy (
        .clk   (clk),
        .rst_n (rst_n),
        .start (busy_start),
        .wip   (wip),
        .done  (busy_done)
    );

    spi_ee_array #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_array (
        .clk     (clk),
        .we      (mem_we),
        .wr_page (q.addr[ADDR_W-1:COL_W]),
        .wr_mask (q.pmask),
        .wr_data (q.pbuf),
        .rd_addr (q.addr),
        .rd_data (rd_data)
    );

    assign status_byte = wip ? 8'hFF : {2'b00, q.wd, q.bl, q.wel, 1'b0};
    assign sh_n        = {q.sh[6:0], spi_si};
    assign src         = (q.ph == PH_RDATA) ? rd_data : status_byte;

    always_comb begin
        d          = q;
        mem_we     = 1'b0;
        busy_start = 1'b0;

        if (busy_done) d.wel = 1'b0;
        if (!spi_wp_n) d.wel = 1'b0;

        if (spi_cs_n) begin
            d.ph       = PH_CMD;
            d.bit_cnt  = '0;
            d.so       = 1'b0;
            d.got_byte = 1'b0;
            d.sr_got   = 1'b0;
            d.pmask    = '0;
            if (cs_rise && !wip && q.wel && spi_wp_n && q.bit_cnt == 3'd0) begin
                if (q.ph == PH_WDATA && q.got_byte && !prot_hit) begin
                    mem_we     = 1'b1;
                    busy_start = 1'b1;
                end else if (q.ph == PH_SRW && q.sr_got) begin
                    d.wd       = q.sr_data[3:2];
                    d.bl       = q.sr_data[1:0];
                    busy_start = 1'b1;
                end
            end
        end else begin
            if (sck_rise) begin
                d.sh      = sh_n;
                d.bit_cnt = q.bit_cnt + 3'd1;
                if (q.bit_cnt == 3'd7) begin
                    unique case (q.ph)
                        PH_CMD: begin
                            if (wip && sh_n != OP_RDSR) begin
                                d.ph = PH_IGN;
                            end else if (sh_n == OP_WREN) begin
                                if (spi_wp_n) d.wel = 1'b1;
                                d.ph = PH_IGN;
                            end else if (sh_n == OP_WRDI) begin
                                d.wel = 1'b0;
                                d.ph  = PH_IGN;
                            end else if (sh_n == OP_RDSR) begin
                                d.ph = PH_SRD;
                            end else if (sh_n == OP_WRSR) begin
                                d.ph = PH_SRW;
                            end else if ((sh_n & ~OP_A8_MASK) == OP_READ ||
                                         (sh_n & ~OP_A8_MASK) == OP_WRITE) begin
                                d.ph               = PH_ADDR;
                                d.rd_op            = sh_n[0];
                                d.addr             = '0;
                                d.addr[ADDR_W-1]   = sh_n[A8_BIT];
                            end else begin
                                d.ph = PH_IGN;
                            end
                        end
                        PH_ADDR: begin
                            d.addr = {q.addr[ADDR_W-1], sh_n};
                            d.col  = sh_n[COL_W-1:0];
                            d.ph   = q.rd_op ? PH_RDATA : PH_WDATA;
                        end
                        PH_WDATA: begin
                            d.pbuf[q.col]  = sh_n;
                            d.pmask[q.col] = 1'b1;
                            d.col          = q.col + 1'b1;
                            d.got_byte     = 1'b1;
                        end
                        PH_RDATA: begin
                            d.addr = q.addr + 1'b1;
                        end
                        PH_SRW: begin
                            d.sr_data = sh_n[5:2];
                            d.sr_got  = 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
            if (sck_fall && (q.ph == PH_RDATA || q.ph == PH_SRD)) begin
                if (q.bit_cnt == 3'd0) begin
                    d.tx = src;
                    d.so = src[7];
                end else begin
                    d.so = q.tx[3'd7 - q.bit_cnt];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.ph      <= PH_CMD;
        end else begin
            q <= d;
        end
    end

    assign spi_so    = q.so;
    assign spi_so_oe = !spi_cs_n && (q.ph == PH_RDATA || q.ph == PH_SRD);

    AST_WE_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> q.wel); // R5
    AST_WE_NOT_PROT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !prot_hit); // R7
    AST_WE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> wip); // R8
    AST_DONE_CLR_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        busy_done |=> !q.wel); // R5
    AST_WP_CLR_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_wp_n |=> !q.wel); // R9
    AST_BUSY_HOLD_SR: assert property (@(posedge clk) disable iff (!rst_n)
        wip |=> $stable(q.bl) && $stable(q.wd)); // R8

endmodule

// File: tb/tb_spi_ee_ctrl.sv
module tb_spi_ee_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int WCYC       = 400;
    localparam int HALF       = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, wp_n = 1'b1;
    logic so, so_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] m_mem [512];
    bit         m_vld [512];
    logic [1:0] m_bl = 2'b00, m_wd = 2'b00;
    bit         m_wel = 1'b0;
    logic [7:0] wbuf [8];

    spi_ee_ctrl #(.PAGE_BYTES(4), .WRITE_CYCLES(WCYC)) dut (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n),
        .spi_si(si), .spi_wp_n(wp_n), .spi_so(so), .spi_so_oe(so_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] exp_status();
        return {2'b00, m_wd, m_bl, m_wel, 1'b0};
    endfunction

    function automatic bit prot(logic [1:0] bl, logic [8:0] a);
        case (bl)
            2'b00:   return 1'b0;
            2'b01:   return a >= 9'h180;
            2'b10:   return a >= 9'h100;
            default: return 1'b1;
        endcase
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wclk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            si = tx[i]; sck = 1'b0; wclk(HALF);
            rx[i] = so; sck = 1'b1; wclk(HALF);
        end
    endtask

    task automatic tstart();
        sck = 1'b0; cs_n = 1'b0; wclk(HALF);
    endtask

    task automatic tend();
        logic [7:0] r;
        r = 8'h00;
        sck = 1'b0; wclk(HALF); cs_n = 1'b1; wclk(HALF);
        chk("R10 oe with cs high", {7'd0, so_oe}, {7'd0, r[0]});
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] r;
        tstart(); xbyte(op, r); tend();
    endtask

    task automatic rdsr(input string req, input logic [7:0] exp);
        logic [7:0] r0, r1;
        tstart(); xbyte(8'h05, r0); xbyte(8'h00, r0); xbyte(8'h00, r1); tend();
        chk(req, r0, exp);
        chk({req, " R4 repeat"}, r1, exp);
    endtask

    task automatic wait_busy();
        wclk(WCYC + 8);
        m_wel = 1'b0;
    endtask

    task automatic set_sr(input logic [7:0] v);
        logic [7:0] r;
        cmd1(8'h06); m_wel = wp_n;
        tstart(); xbyte(8'h01, r); xbyte(v, r); tend();
        if (m_wel) begin
            rdsr("R8 busy after status write", 8'hFF);
            wait_busy();
            m_wd = v[5:4]; m_bl = v[3:2];
        end
        rdsr("R4 status after write", exp_status());
    endtask

    task automatic wr_page(input logic [8:0] a, input int n);
        logic [7:0] r;
        bit commit;
        tstart();
        xbyte({4'b0000, a[8], 3'b010}, r);
        xbyte(a[7:0], r);
        for (int k = 0; k < n; k++) xbyte(wbuf[k], r);
        tend();
        commit = m_wel && (n > 0) && !prot(m_bl, a);
        if (commit) begin
            for (int k = 0; k < n; k++) begin
                logic [8:0] ad;
                ad = {a[8:2], 2'(a[1:0] + 2'(k))};
                m_mem[ad] = wbuf[k]; m_vld[ad] = 1'b1;
            end
            rdsr("R8 busy after write", 8'hFF);
            wait_busy();
            rdsr("R5 latch cleared after write", exp_status());
        end else begin
            rdsr("R7 refused write no busy", exp_status());
        end
    endtask

    task automatic rd_check(input string req, input logic [8:0] a, input int n);
        logic [7:0] r;
        tstart();
        xbyte({4'b0000, a[8], 3'b011}, r);
        xbyte(a[7:0], r);
        chk("R10 oe during read", {7'd0, so_oe}, 8'd1);
        for (int k = 0; k < n; k++) begin
            logic [8:0] ad;
            ad = 9'(a + 9'(k));
            xbyte(8'h00, r);
            if (m_vld[ad]) chk(req, r, m_mem[ad]);
        end
        tend();
    endtask

    initial begin
        wclk(190000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 512; i++) m_vld[i] = 1'b0;
        wclk(5); rst_n = 1'b1; wclk(5);

        chk("R10 reset oe", {7'd0, so_oe}, 8'd0);
        rdsr("R10 reset status", 8'h00);

        cmd1(8'h06); m_wel = 1'b1;
        rdsr("R3 latch set", 8'h02);
        cmd1(8'h04); m_wel = 1'b0;
        rdsr("R3 latch clear", 8'h00);

        // R6 page wrap: start 0x005, six bytes
        for (int k = 0; k < 6; k++) wbuf[k] = 8'(8'h11 * (k + 1));
        cmd1(8'h06); m_wel = 1'b1;
        wr_page(9'h005, 6);
        rd_check("R6 page wrap", 9'h004, 4);
        chk("R6 lane 4", m_mem[9'h004], 8'h44);

        // R2 high address bit and wrap of the read address
        wbuf[0] = 8'h5A; cmd1(8'h06); m_wel = 1'b1; wr_page(9'h1FF, 1);
        wbuf[0] = 8'h77; cmd1(8'h06); m_wel = 1'b1; wr_page(9'h000, 1);
        wbuf[0] = 8'hC3; cmd1(8'h06); m_wel = 1'b1; wr_page(9'h0FF, 1);
        rd_check("R2 read wrap", 9'h1FF, 2);
        rd_check("R2 low half", 9'h0FF, 1);

        // R5 write without latch is refused
        wbuf[0] = 8'h99; wr_page(9'h000, 1);
        rd_check("R5 no latch no write", 9'h000, 1);

        // R5 partial byte is refused
        cmd1(8'h06); m_wel = 1'b1;
        tstart(); xbyte(8'h02, r); xbyte(8'h00, r); xbyte(8'hEE, r);
        for (int i = 0; i < 3; i++) begin
            si = 1'b1; sck = 1'b0; wclk(HALF); sck = 1'b1; wclk(HALF);
        end
        tend();
        rdsr("R5 partial byte no commit", 8'h02);
        rd_check("R5 partial byte array", 9'h000, 1);
        cmd1(8'h04); m_wel = 1'b0;

        // R4 status write masks bits 7:6 and 1:0
        set_sr(8'hFF);
        rdsr("R4 status fields", 8'h3C);
        set_sr(8'h00);

        // R7 directed boundaries
        set_sr(8'h04);
        wbuf[0] = 8'h12; cmd1(8'h06); m_wel = 1'b1; wr_page(9'h180, 1);
        wbuf[0] = 8'h34; wr_page(9'h17F, 1);
        set_sr(8'h08);
        wbuf[0] = 8'h56; cmd1(8'h06); m_wel = 1'b1; wr_page(9'h100, 1);
        wbuf[0] = 8'h78; wr_page(9'h0FE, 1);
        set_sr(8'h0C);
        wbuf[0] = 8'h9A; cmd1(8'h06); m_wel = 1'b1; wr_page(9'h000, 1);
        rd_check("R7 protected reads", 9'h0FE, 4);
        cmd1(8'h04); m_wel = 1'b0;

        // R7 random protection and page writes
        for (int it = 0; it < 22; it++) begin
            logic [8:0] a;
            int n;
            set_sr({2'b00, 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), 2'b00});
            a = 9'($urandom_range(0, 511));
            n = $urandom_range(1, 6);
            for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
            cmd1(8'h06); m_wel = 1'b1;
            wr_page(a, n);
            if (m_wel) begin cmd1(8'h04); m_wel = 1'b0; end
        end
        set_sr(8'h00);

        // R8 instruction during busy is discarded
        wbuf[0] = 8'hA1; cmd1(8'h06); m_wel = 1'b1;
        tstart(); xbyte(8'h02, r); xbyte(8'h40, r); xbyte(wbuf[0], r); tend();
        m_mem[9'h040] = 8'hA1; m_vld[9'h040] = 1'b1;
        cmd1(8'h06);
        rdsr("R8 status during busy", 8'hFF);
        wait_busy();
        rdsr("R8 WREN during busy ignored", 8'h00);

        // R9 write protect
        cmd1(8'h06); m_wel = 1'b1;
        wp_n = 1'b0; wclk(2); m_wel = 1'b0;
        rdsr("R9 wp clears latch", 8'h00);
        cmd1(8'h06);
        rdsr("R9 WREN blocked by wp", 8'h00);
        rd_check("R9 read with wp low", 9'h040, 1);
        wp_n = 1'b1; wclk(2);
        rdsr("R9 latch stays clear", 8'h00);

        // R9 wp pulse during a write transaction
        cmd1(8'h06); m_wel = 1'b1;
        tstart(); xbyte(8'h02, r); xbyte(8'h40, r);
        wp_n = 1'b0; xbyte(8'h5E, r); wp_n = 1'b1; tend();
        m_wel = 1'b0;
        rdsr("R9 write refused after wp", 8'h00);

        // R1 R2 full readback with wrap
        rd_check("R1 full readback", 9'h000, 513);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule